// File: doc/BRIEF.md
# Reloadable Baud Rate Generator

This block produces the bit-rate enable for a serial port. A 13-bit timer counts down by one on every second system clock cycle. When it passes zero it loads itself from a 13-bit reload register and issues one tick. The tick stream can be thinned to two thirds of its rate. It is then divided by 16 in asynchronous mode or by 4 in synchronous mode, and the result is a one-cycle bit-clock enable.

A single 16-bit register port serves both directions. A read returns the live timer value, and a write sets only the reload value. A run control starts and stops the whole chain. While the chain is stopped the timer keeps its value and every downstream divider is held cleared.

Top module: `baud_gen`

## Requirements
- R1: After reset, `rd_data` reads 0 and `tick_o`, `scaled_tick_o` and `bit_en_o` are all low.
- R2: While `run_en` is high, the timer takes one step every second clock cycle. A step at a nonzero count lowers the count by exactly one.
- R3: A step taken at count zero raises `tick_o` for that one cycle and loads the timer from the reload register, so reload value V gives ticks spaced 2*(V+1) cycles apart.
- R4: While `run_en` is low, the timer keeps its value and no tick, scaled tick or bit enable is produced.
- R5: Reload value 0 makes every step an underflow, so ticks arrive every 2 cycles.
- R6: With `rate_23_en` low, every tick reaches `scaled_tick_o`. With it high, the ticks since the last time the scaler was cleared (stopped or disabled) pass in the pattern pass, pass, drop.
- R7: `bit_en_o` pulses for one cycle on every 16th scaled tick when `sync_mode` is 0 (asynchronous), and on every 4th scaled tick when `sync_mode` is 1 (synchronous). The count starts when the chain starts running.
- R8: `rd_data` is the live 13-bit count in bits 12..0, and bits 15..13 read as zero.
- R9: A write with `wr_en` updates only the reload register, taking `wr_data[12:0]` and ignoring `wr_data[15:13]`. The live count is not changed by the write.
- R10: Stopping clears the step phase. The first step after `run_en` rises falls in the second cycle that `run_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Starts (1) or stops (0) the timer and the dividers |
| rate_23_en | input | 1 | Enables the two-thirds tick scaler |
| sync_mode | input | 1 | 0 selects divide by 16, 1 selects divide by 4 |
| wr_en | input | 1 | Writes `wr_data` to the reload register |
| wr_data | input | 16 | Reload write data; bits 15..13 are ignored |
| rd_data | output | 16 | Live timer value, zero-extended |
| tick_o | output | 1 | One-cycle underflow tick |
| scaled_tick_o | output | 1 | Tick after the two-thirds scaler |
| bit_en_o | output | 1 | One-cycle serial bit-clock enable |

## Verification
The three pulse outputs are decoded from register state within the cycle, so they are valid in the same cycle that the step phase and the count reach their trigger values. `rd_data` shows the result of a step or a reload one clock edge after the step. A reload write changes what the timer loads at the next underflow and nothing else. The bench keeps a reference model that is advanced at each rising edge from the inputs held during that cycle, and it compares all four outputs at every falling edge. Inputs change only just after a falling edge. Directed measurements count falling-edge samples between ticks and over fixed windows that start when `run_en` rises, which exposes the one-cycle step delay after a restart.

// File: rtl/bg_pkg.sv
package bg_pkg;

  typedef enum logic {
    BG_ASYNC = 1'b0,
    BG_SYNC  = 1'b1
  } bg_mode_e;

  // Next timer value on a step: wrap to the reload value at zero.
  function automatic logic [31:0] bg_next_count(input logic [31:0] cur,
                                                input logic [31:0] rel);
    return (cur == 32'd0) ? rel : cur - 32'd1;
  endfunction

  // Two-thirds scaler: the third tick of every group of three is dropped.
  function automatic logic bg_frac_pass(input logic en, input logic [1:0] ph);
    return !(en && (ph == 2'd2));
  endfunction

  function automatic logic [1:0] bg_frac_adv(input logic [1:0] ph);
    return (ph == 2'd2) ? 2'd0 : ph + 2'd1;
  endfunction

  // Division ratio chosen by the operating mode.
  function automatic int unsigned bg_mode_div(input bg_mode_e m,
                                              input int unsigned adiv,
                                              input int unsigned sdiv);
    return (m == BG_SYNC) ? sdiv : adiv;
  endfunction

endpackage

// File: rtl/bg_prescale.sv
module bg_prescale #(
  parameter int unsigned PRE_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic step_o
);
  localparam int unsigned PH_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PRE_DIV - 1);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               ph_q <= '0;
    else if (!run)            ph_q <= '0;
    else if (ph_q == PH_LAST) ph_q <= '0;
    else                      ph_q <= ph_q + 1'b1;
  end

  assign step_o = run && (ph_q == PH_LAST);
endmodule

// File: rtl/bg_timer.sv
module bg_timer
  import bg_pkg::*;
#(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             uflow_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] rel_q;
  logic [CNT_W-1:0] cnt_next;

  assign cnt_next = CNT_W'(bg_next_count(32'(cnt_q), 32'(rel_q)));

  always_ff @(posedge clk) begin
    if (!rst_n)    rel_q <= '0;
    else if (wr_en) rel_q <= wr_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= cnt_next;
  end

  assign uflow_o  = step && (cnt_q == '0);
  assign cnt_o    = cnt_q;
  assign reload_o = rel_q;
endmodule

// File: rtl/bg_frac.sv
module bg_frac
  import bg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic en,
  input  logic tick_in,
  output logic tick_out
);
  logic [1:0] m3_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           m3_q <= 2'd0;
    else if (!run || !en) m3_q <= 2'd0;
    else if (tick_in)     m3_q <= bg_frac_adv(m3_q);
  end

  assign tick_out = tick_in && bg_frac_pass(en, m3_q);
endmodule

// File: rtl/bg_modediv.sv
module bg_modediv
  import bg_pkg::*;
#(
  parameter int unsigned ASYNC_DIV = 16,
  parameter int unsigned SYNC_DIV  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sync_mode,
  input  logic tick_in,
  output logic en_o
);
  localparam int unsigned MAX_DIV = (ASYNC_DIV > SYNC_DIV) ? ASYNC_DIV : SYNC_DIV;
  localparam int unsigned DIV_W   = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

  logic [DIV_W-1:0] d_q;
  logic [DIV_W-1:0] last;
  logic             wrap;

  assign last = DIV_W'(bg_mode_div(bg_mode_e'(sync_mode), ASYNC_DIV, SYNC_DIV) - 1);
  assign wrap = run && tick_in && (d_q >= last);

  always_ff @(posedge clk) begin
    if (!rst_n)       d_q <= '0;
    else if (!run)    d_q <= '0;
    else if (tick_in) d_q <= wrap ? '0 : d_q + 1'b1;
  end

  assign en_o = wrap;
endmodule

// File: rtl/baud_gen.sv
module baud_gen #(
  parameter int unsigned CNT_W     = 13,
  parameter int unsigned BUS_W     = 16,
  parameter int unsigned PRE_DIV   = 2,
  parameter int unsigned ASYNC_DIV = 16,
  parameter int unsigned SYNC_DIV  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             rate_23_en,
  input  logic             sync_mode,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_data,
  output logic [BUS_W-1:0] rd_data,
  output logic             tick_o,
  output logic             scaled_tick_o,
  output logic             bit_en_o
);
  localparam int unsigned PAD_W = BUS_W - CNT_W;

  // Named internal events, visible to the bound checker.
  logic             step_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] reload_w;
  logic             uflow_w;
  logic             scaled_w;
  logic             bit_w;

  wire unused_hi_bits = ^wr_data[BUS_W-1:CNT_W];

  bg_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_en),
    .step_o (step_w)
  );

  bg_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step_w),
    .wr_en    (wr_en),
    .wr_val   (wr_data[CNT_W-1:0]),
    .cnt_o    (cnt_w),
    .reload_o (reload_w),
    .uflow_o  (uflow_w)
  );

  bg_frac u_frac (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_en),
    .en       (rate_23_en),
    .tick_in  (uflow_w),
    .tick_out (scaled_w)
  );

  bg_modediv #(.ASYNC_DIV(ASYNC_DIV), .SYNC_DIV(SYNC_DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_en),
    .sync_mode (sync_mode),
    .tick_in   (scaled_w),
    .en_o      (bit_w)
  );

  assign rd_data       = {{PAD_W{1'b0}}, cnt_w};
  assign tick_o        = uflow_w;
  assign scaled_tick_o = scaled_w;
  assign bit_en_o      = bit_w;
endmodule

// File: rtl/bg_checker.sv
module bg_checker #(
  parameter int unsigned CNT_W   = 13,
  parameter int unsigned BUS_W   = 16,
  parameter int unsigned PRE_DIV = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             step,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload,
  input logic             tick,
  input logic             scaled,
  input logic             bit_en,
  input logic [BUS_W-1:0] rd_data
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // R2: a step at a nonzero count lowers it by one
  a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt != '0) |=> (cnt == $past(cnt) - ONE));

  generate
    if (PRE_DIV > 1) begin : g_spacing
      // R2: steps never fall in back-to-back cycles
      a_r2_step_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step);
    end
  endgenerate

  // R3: an underflow tick is followed by the reload value in the timer
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == $past(reload)));

  // R4: stopped timer keeps its value
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (cnt == $past(cnt)));

  // R4: stopped chain is silent
  a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> (!tick && !scaled && !bit_en));

  // R6: scaled ticks are a subset of raw ticks
  a_r6_subset: assert property (@(posedge clk) disable iff (!rst_n)
    scaled |-> tick);

  // R7: bit enables are a subset of scaled ticks
  a_r7_subset: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |-> scaled);

  // R8: upper read bits are zero and the low bits follow the timer
  a_r8_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[BUS_W-1:CNT_W] == '0) && (rd_data[CNT_W-1:0] == cnt));
endmodule

bind baud_gen bg_checker #(.CNT_W(CNT_W), .BUS_W(BUS_W), .PRE_DIV(PRE_DIV)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run_en  (run_en),
  .step    (step_w),
  .cnt     (cnt_w),
  .reload  (reload_w),
  .tick    (tick_o),
  .scaled  (scaled_tick_o),
  .bit_en  (bit_en_o),
  .rd_data (rd_data)
);

// File: tb/baud_gen_tb.sv
module baud_gen_tb;
  localparam int AD = 16;
  localparam int SD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        rate_23_en = 1'b0;
  logic        sync_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = 16'h0;
  wire  [15:0] rd_data;
  wire         tick_o, scaled_tick_o, bit_en_o;

  always #2.5 clk = ~clk;

  baud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .rate_23_en(rate_23_en),
    .sync_mode(sync_mode), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .tick_o(tick_o), .scaled_tick_o(scaled_tick_o), .bit_en_o(bit_en_o)
  );

  int checks = 0;
  int fails = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model, written from the requirements
  bit m_ph;
  int m_cnt, m_rel, m_fidx, m_sc;

  function automatic int exp_div(input bit s);
    return s ? SD : AD;
  endfunction
  function automatic bit e_step();
    return run_en && m_ph;
  endfunction
  function automatic bit e_raw();
    return e_step() && (m_cnt == 0);
  endfunction
  function automatic bit e_scaled();
    return e_raw() && !(rate_23_en && m_fidx == 2);
  endfunction
  function automatic bit e_bit();
    return e_scaled() && (m_sc == exp_div(sync_mode) - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph <= 1'b0; m_cnt <= 0; m_rel <= 0; m_fidx <= 0; m_sc <= 0;
    end else begin
      m_ph <= run_en ? !m_ph : 1'b0;
      if (wr_en) m_rel <= int'(wr_data) % 8192;
      if (e_step()) m_cnt <= (m_cnt == 0) ? m_rel : m_cnt - 1;
      if (!run_en || !rate_23_en) m_fidx <= 0;
      else if (e_raw()) m_fidx <= (m_fidx + 1) % 3;
      if (!run_en) m_sc <= 0;
      else if (e_scaled()) m_sc <= (m_sc + 1) % exp_div(sync_mode);
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk("R2/R8 count", rd_data, m_cnt);
      chk("R3 tick", tick_o, e_raw());
      chk("R6 scaled tick", scaled_tick_o, e_scaled());
      chk("R7 bit enable", bit_en_o, e_bit());
    end
  end

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick_o && n < 20000);
  endtask

  task automatic set_run(input bit r);
    @(negedge clk); #1;
    run_en = r;
  endtask

  task automatic write_reload(input logic [15:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic window(input int len, output int nr, output int ns, output int nb);
    nr = 0; ns = 0; nb = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      nr += int'(tick_o); ns += int'(scaled_tick_o); nb += int'(bit_en_o);
    end
  endtask

  task automatic run_window(input bit frac, input bit smode,
                            input int exp_s, input int exp_b);
    int nr, ns, nb;
    set_run(1'b0);
    rate_23_en = frac; sync_mode = smode;
    @(negedge clk); #1;
    run_en = 1'b1;
    window(64, nr, ns, nb);
    chk("R5 raw ticks in window", nr, 32);
    chk("R6 scaled ticks in window", ns, exp_s);
    chk("R7 bit enables in window", nb, exp_b);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, v, nr, ns, nb;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rd_data", rd_data, 0);
    chk("R1 tick", tick_o, 0);
    chk("R1 bit enable", bit_en_o, 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd_data after release", rd_data, 0);
    cmp_on = 1'b1;

    // R9: write with upper bits set, count untouched while stopped
    write_reload(16'hE005);
    chk("R9 count unchanged by write", rd_data, 0);
    set_run(1'b1);
    wait_tick(n);
    chk("R10 first step in second run cycle", n, 1);
    @(negedge clk);
    chk("R9 reload low bits only", rd_data, 5);
    wait_tick(n);
    chk("R3 period for reload 5", n + 1, 12);
    wait_tick(n);
    chk("R3 period repeat", n, 12);

    // R4: stop mid-count
    write_reload(16'd100);
    repeat (30) @(negedge clk);
    set_run(1'b0);
    @(negedge clk);
    v = int'(rd_data);
    window(10, nr, ns, nb);
    chk("R4 count held", rd_data, v);
    chk("R4 no ticks while stopped", nr + ns + nb, 0);

    // R5: reload zero
    write_reload(16'h2000);
    set_run(1'b1);
    wait_tick(n);
    wait_tick(n);
    chk("R5 period for reload 0", n, 2);
    wait_tick(n);
    chk("R5 period repeat", n, 2);

    // R10: restart after a stop
    set_run(1'b0);
    repeat (3) @(negedge clk);
    #1 run_en = 1'b1;
    @(negedge clk);
    chk("R10 tick at first sample after restart", tick_o, 1);
    @(negedge clk);
    chk("R10 no tick on off phase", tick_o, 0);

    // R6 / R7 windows with reload 0
    run_window(1'b0, 1'b0, 32, 2);
    run_window(1'b0, 1'b1, 32, 8);
    run_window(1'b1, 1'b1, 22, 5);
    run_window(1'b1, 1'b0, 22, 1);

    // Random mix checked cycle by cycle against the model
    for (int seg = 0; seg < 400; seg++) begin
      int op;
      op = int'($urandom % 8);
      @(negedge clk); #1;
      case (op)
        0, 1: begin
          wr_en = 1'b1;
          wr_data = {3'($urandom), 13'(($urandom % 4 == 0) ? $urandom % 40 : $urandom % 8)};
        end
        2: run_en = !run_en;
        3: rate_23_en = 1'($urandom);
        4: if (!run_en) sync_mode = 1'($urandom);
        default: run_en = 1'b1;
      endcase
      @(negedge clk); #1;
      wr_en = 1'b0;
      repeat (int'($urandom % 20)) @(negedge clk);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule